// File: doc/BRIEF.md
# CAN FD Interrupt Status and Error Capture Unit

This unit sits beside the protocol engine of a CAN FD controller and turns its single-cycle event pulses into host-visible state. Each of fifteen event sources sets a sticky bit in an interrupt status register. The host clears a bit by writing a 1 to it. A per-source mask register decides which pending bits reach the single registered interrupt line.

Two capture registers record detail for the host. When the engine reports a bus error, the unit stores a packed error code: the error kind, whether the node was receiving or transmitting, and a 16-bit location code from the engine. When the engine reports lost arbitration, the unit stores the arbitration code it supplies. Neither capture register changes unless its own event fires.

Host access is a plain register port. It has a write strobe, a two-bit address and write data. Read data is registered and follows the address one clock later.

Top module: `canfd_irq_status`

## Requirements
- R1: After synchronous reset the following hold: status reads 0, the mask reads 0x7FFF (all fifteen sources masked), both capture registers read 0, and `irq_o` is 0.
- R2: A pulse on `evt_i[n]` sets status bit n at the next clock edge, and the bit stays set until the host clears it. The source map is: 0 receive done, 1 transmit done, 2 error warning, 3 receive buffer overrun, 4 error passive, 5 arbitration lost, 6 bus error, 7 receive FIFO full, 8 receive FIFO overflow, 9 bus-off, 10 bus-off recovery, 11 timestamp counter overflow, 12 transmit event FIFO overflow, 13 transmit event FIFO full, 14 wakeup.
- R3: A write to address 0 (status) clears each status bit whose write-data bit is 1 and leaves bits written 0 unchanged.
- R4: When an event pulse and a host clear hit the same status bit in the same cycle, the bit ends up set.
- R5: `irq_o` is the registered OR over all sources of (status AND NOT mask). It is 1 one clock after a pending unmasked bit exists, and 0 while every pending bit is masked.
- R6: A write to address 1 (mask) stores the low 15 bits. Writing 0 unmasks every source, and writing 0xFFFF masks every source and reads back 0x7FFF.
- R7: A pulse on source 6 (bus error) loads the error code register at address 2 as follows: bits 28:26 hold the kind (bit=0, stuff=1, form=2, ack=3, crc=4), bit 25 is 1 for an error seen while receiving and 0 for one seen while transmitting, bits 15:0 hold the location code, and all other bits are 0.
- R8: A pulse on source 5 (arbitration lost) loads the arbitration code input into the register at address 3.
- R9: Both capture registers hold their value in every cycle without their own event, whatever the code inputs do. Host writes to addresses 2 and 3 have no effect.
- R10: `reg_rdata_o` presents the register selected by `reg_addr_i` one clock after the address is applied. Unused upper bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | NSRC (15) | One-cycle event pulses from the protocol engine |
| berr_kind_i | input | 3 | Bus error kind code |
| berr_rx_i | input | 1 | 1 when the bus error was seen while receiving |
| berr_loc_i | input | LOC_W (16) | Bus error location code |
| arb_code_i | input | ARB_W (8) | Code at the point arbitration was lost |
| reg_wr_i | input | 1 | Host write strobe |
| reg_addr_i | input | AW (2) | Host register address |
| reg_wdata_i | input | DW (32) | Host write data |
| reg_rdata_o | output | DW (32) | Registered host read data |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The situation hardest to reach from the ports is a host clear that lands in the same clock as a new event on the same bit. A bench issuing reads and writes one at a time never lines these up by accident. The stimulus therefore drives the event pulse and the status write together on one negative edge, then reads the status back. The hold behaviour of the capture registers is exposed the same way: the code inputs are changed to new values with no event pulse, and the registers must still return the old codes.

// File: rtl/canirq_pkg.sv
package canirq_pkg;
  localparam int NUM_SRC = 15;

  // event source indices that other logic decodes
  localparam int SRC_ARB_LOST = 5;
  localparam int SRC_BUS_ERR  = 6;

  // register addresses
  localparam int ADDR_STATUS  = 0;
  localparam int ADDR_MASK    = 1;
  localparam int ADDR_ERRCODE = 2;
  localparam int ADDR_ARB     = 3;

  // packed error code field positions
  localparam int EC_KIND_LSB = 26;
  localparam int EC_KIND_W   = 3;
  localparam int EC_DIR_BIT  = 25;

  typedef enum logic [2:0] {
    EK_BIT   = 3'd0,
    EK_STUFF = 3'd1,
    EK_FORM  = 3'd2,
    EK_ACK   = 3'd3,
    EK_CRC   = 3'd4
  } err_kind_e;
endpackage

// File: rtl/canirq_status.sv
module canirq_status #(
  parameter int NSRC = canirq_pkg::NUM_SRC
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] evt_i,
  input  logic            clr_we_i,
  input  logic            mask_we_i,
  input  logic [NSRC-1:0] wdata_i,
  output logic [NSRC-1:0] status_o,
  output logic [NSRC-1:0] mask_o,
  output logic            irq_o
);
  logic [NSRC-1:0] st_q;
  logic [NSRC-1:0] mk_q;
  logic            irq_q;

  // per-source sticky bit: a new event wins over a same-cycle clear
  for (genvar g = 0; g < NSRC; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)
        st_q[g] <= 1'b0;
      else if (evt_i[g])
        st_q[g] <= 1'b1;
      else if (clr_we_i && wdata_i[g])
        st_q[g] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      mk_q <= '1;
    else if (mask_we_i)
      mk_q <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (rst)
      irq_q <= 1'b0;
    else
      irq_q <= |(st_q & ~mk_q);
  end

  assign status_o = st_q;
  assign mask_o   = mk_q;
  assign irq_o    = irq_q;
endmodule

// File: rtl/canirq_capture.sv
module canirq_capture #(
  parameter int DW    = 32,
  parameter int LOC_W = 16,
  parameter int ARB_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             berr_evt_i,
  input  logic [2:0]       berr_kind_i,
  input  logic             berr_rx_i,
  input  logic [LOC_W-1:0] berr_loc_i,
  input  logic             arb_evt_i,
  input  logic [ARB_W-1:0] arb_code_i,
  output logic [DW-1:0]    errcode_o,
  output logic [ARB_W-1:0] arb_o
);
  import canirq_pkg::*;

  logic [DW-1:0]    ec_next;
  logic [DW-1:0]    ec_q;
  logic [ARB_W-1:0] arb_q;

  always_comb begin
    ec_next = '0;
    ec_next[EC_KIND_LSB +: EC_KIND_W] = berr_kind_i;
    ec_next[EC_DIR_BIT]               = berr_rx_i;
    ec_next[LOC_W-1:0]                = berr_loc_i;
  end

  always_ff @(posedge clk) begin
    if (rst)
      ec_q <= '0;
    else if (berr_evt_i)
      ec_q <= ec_next;
  end

  always_ff @(posedge clk) begin
    if (rst)
      arb_q <= '0;
    else if (arb_evt_i)
      arb_q <= arb_code_i;
  end

  assign errcode_o = ec_q;
  assign arb_o     = arb_q;
endmodule

// File: rtl/canirq_regmux.sv
module canirq_regmux #(
  parameter int NSRC  = canirq_pkg::NUM_SRC,
  parameter int DW    = 32,
  parameter int AW    = 2,
  parameter int ARB_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    addr_i,
  input  logic [NSRC-1:0]  status_i,
  input  logic [NSRC-1:0]  mask_i,
  input  logic [DW-1:0]    errcode_i,
  input  logic [ARB_W-1:0] arb_i,
  output logic [DW-1:0]    rdata_o
);
  import canirq_pkg::*;

  logic [DW-1:0] sel;
  logic [DW-1:0] rd_q;

  always_comb begin
    sel = '0;
    if (addr_i == AW'(ADDR_STATUS))
      sel[NSRC-1:0] = status_i;
    else if (addr_i == AW'(ADDR_MASK))
      sel[NSRC-1:0] = mask_i;
    else if (addr_i == AW'(ADDR_ERRCODE))
      sel = errcode_i;
    else if (addr_i == AW'(ADDR_ARB))
      sel[ARB_W-1:0] = arb_i;
  end

  always_ff @(posedge clk) begin
    if (rst)
      rd_q <= '0;
    else
      rd_q <= sel;
  end

  assign rdata_o = rd_q;
endmodule

// File: rtl/canfd_irq_status.sv
module canfd_irq_status #(
  parameter int NSRC  = canirq_pkg::NUM_SRC,
  parameter int DW    = 32,
  parameter int AW    = 2,
  parameter int LOC_W = 16,
  parameter int ARB_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NSRC-1:0]  evt_i,
  input  logic [2:0]       berr_kind_i,
  input  logic             berr_rx_i,
  input  logic [LOC_W-1:0] berr_loc_i,
  input  logic [ARB_W-1:0] arb_code_i,
  input  logic             reg_wr_i,
  input  logic [AW-1:0]    reg_addr_i,
  input  logic [DW-1:0]    reg_wdata_i,
  output logic [DW-1:0]    reg_rdata_o,
  output logic             irq_o
);
  import canirq_pkg::*;

  logic            clr_we;
  logic            mask_we;
  logic [NSRC-1:0] status_q;
  logic [NSRC-1:0] mask_q;
  logic [DW-1:0]   errcode_q;
  logic [ARB_W-1:0] arb_q;

  assign clr_we  = reg_wr_i && (reg_addr_i == AW'(ADDR_STATUS));
  assign mask_we = reg_wr_i && (reg_addr_i == AW'(ADDR_MASK));

  canirq_status #(.NSRC(NSRC)) u_status (
    .clk       (clk),
    .rst       (rst),
    .evt_i     (evt_i),
    .clr_we_i  (clr_we),
    .mask_we_i (mask_we),
    .wdata_i   (reg_wdata_i[NSRC-1:0]),
    .status_o  (status_q),
    .mask_o    (mask_q),
    .irq_o     (irq_o)
  );

  canirq_capture #(.DW(DW), .LOC_W(LOC_W), .ARB_W(ARB_W)) u_capture (
    .clk         (clk),
    .rst         (rst),
    .berr_evt_i  (evt_i[SRC_BUS_ERR]),
    .berr_kind_i (berr_kind_i),
    .berr_rx_i   (berr_rx_i),
    .berr_loc_i  (berr_loc_i),
    .arb_evt_i   (evt_i[SRC_ARB_LOST]),
    .arb_code_i  (arb_code_i),
    .errcode_o   (errcode_q),
    .arb_o       (arb_q)
  );

  canirq_regmux #(.NSRC(NSRC), .DW(DW), .AW(AW), .ARB_W(ARB_W)) u_regmux (
    .clk       (clk),
    .rst       (rst),
    .addr_i    (reg_addr_i),
    .status_i  (status_q),
    .mask_i    (mask_q),
    .errcode_i (errcode_q),
    .arb_i     (arb_q),
    .rdata_o   (reg_rdata_o)
  );
endmodule

// File: rtl/canirq_chk.sv
module canirq_chk #(
  parameter int NSRC  = canirq_pkg::NUM_SRC,
  parameter int DW    = 32,
  parameter int AW    = 2,
  parameter int LOC_W = 16,
  parameter int ARB_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [NSRC-1:0]  evt_i,
  input logic [2:0]       berr_kind_i,
  input logic             berr_rx_i,
  input logic [LOC_W-1:0] berr_loc_i,
  input logic [ARB_W-1:0] arb_code_i,
  input logic             reg_wr_i,
  input logic [AW-1:0]    reg_addr_i,
  input logic [DW-1:0]    reg_wdata_i,
  input logic [NSRC-1:0]  status_q,
  input logic [NSRC-1:0]  mask_q,
  input logic [DW-1:0]    errcode_q,
  input logic [ARB_W-1:0] arb_q,
  input logic             irq_o
);
  import canirq_pkg::*;

  // R2 and R4: every pulsed source is set afterwards, clear or not
  a_r2_event_sets: assert property (@(posedge clk) disable iff (rst)
    (|evt_i) |=> ((status_q & $past(evt_i)) == $past(evt_i)));

  // R2: a status bit only rises when its event fired
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((status_q & ~$past(status_q) & ~$past(evt_i)) == '0));

  // R3: bits written 1 without a coincident event are cleared
  a_r3_clear: assert property (@(posedge clk) disable iff (rst)
    (reg_wr_i && reg_addr_i == AW'(ADDR_STATUS) && |(reg_wdata_i[NSRC-1:0] & ~evt_i))
    |=> ((status_q & $past(reg_wdata_i[NSRC-1:0] & ~evt_i)) == '0));

  // R5: interrupt line follows unmasked pending bits one clock later
  a_r5_irq: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_o == |($past(status_q) & ~$past(mask_q))));

  // R7: bus error loads the packed code
  a_r7_capture: assert property (@(posedge clk) disable iff (rst)
    evt_i[SRC_BUS_ERR] |=>
      (errcode_q[EC_KIND_LSB +: EC_KIND_W] == $past(berr_kind_i)) &&
      (errcode_q[EC_DIR_BIT] == $past(berr_rx_i)) &&
      (errcode_q[LOC_W-1:0] == $past(berr_loc_i)));

  // R8: lost arbitration loads the code
  a_r8_capture: assert property (@(posedge clk) disable iff (rst)
    evt_i[SRC_ARB_LOST] |=> (arb_q == $past(arb_code_i)));

  // R9: captures hold without their event
  a_r9_err_hold: assert property (@(posedge clk) disable iff (rst)
    !evt_i[SRC_BUS_ERR] |=> $stable(errcode_q));

  a_r9_arb_hold: assert property (@(posedge clk) disable iff (rst)
    !evt_i[SRC_ARB_LOST] |=> $stable(arb_q));
endmodule

bind canfd_irq_status canirq_chk #(
  .NSRC(NSRC), .DW(DW), .AW(AW), .LOC_W(LOC_W), .ARB_W(ARB_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .evt_i       (evt_i),
  .berr_kind_i (berr_kind_i),
  .berr_rx_i   (berr_rx_i),
  .berr_loc_i  (berr_loc_i),
  .arb_code_i  (arb_code_i),
  .reg_wr_i    (reg_wr_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .status_q    (status_q),
  .mask_q      (mask_q),
  .errcode_q   (errcode_q),
  .arb_q       (arb_q),
  .irq_o       (irq_o)
);

// File: tb/canfd_irq_status_tb.sv
module canfd_irq_status_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [14:0] evt_i = '0;
  logic [2:0]  berr_kind_i = '0;
  logic        berr_rx_i = 1'b0;
  logic [15:0] berr_loc_i = '0;
  logic [7:0]  arb_code_i = '0;
  logic        reg_wr_i = 1'b0;
  logic [1:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        irq_o;

  int n_chk = 0;
  int n_fail = 0;

  logic        rd_req = 1'b0;
  logic        rd_seen = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  canfd_irq_status u_dut (
    .clk(clk), .rst(rst), .evt_i(evt_i), .berr_kind_i(berr_kind_i),
    .berr_rx_i(berr_rx_i), .berr_loc_i(berr_loc_i), .arb_code_i(arb_code_i),
    .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .irq_o(irq_o)
  );

  always @(posedge clk) rd_seen <= rd_req;

  // monitor: compare read results against the scoreboard
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_chk++;
      if (reg_rdata_o !== e) begin
        n_fail++;
        $display("FAIL %s: read 0x%08h expected 0x%08h", t, reg_rdata_o, e);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk);
    reg_wr_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] e, input string t);
    reg_addr_i = a; rd_req = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic pulse(input logic [14:0] v);
    evt_i = v;
    @(negedge clk);
    evt_i = '0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    n_chk++;
    if (irq_o !== e) begin
      n_fail++;
      $display("FAIL %s: irq %0b expected %0b", t, irq_o, e);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk_irq(1'b0, "R1 irq after reset");
    rd(2'd0, 32'h0, "R1 status after reset");
    rd(2'd1, 32'h7FFF, "R1 mask after reset");
    rd(2'd2, 32'h0, "R1 errcode after reset");
    rd(2'd3, 32'h0, "R1 arb after reset");

    // R2 events latch; R5 masked sources keep irq low
    pulse(15'h4001);
    rd(2'd0, 32'h4001, "R2 rx done and wakeup latched");
    rd(2'd0, 32'h4001, "R2 bits stay set");
    chk_irq(1'b0, "R5 all masked keeps irq low");

    // R6 unmask all; R5 irq rises
    wr(2'd1, 32'h0);
    @(negedge clk);
    chk_irq(1'b1, "R5 irq with unmasked pending");
    rd(2'd1, 32'h0, "R6 mask zero");

    // R3 clear one bit, written zero leaves others
    wr(2'd0, 32'h0001);
    rd(2'd0, 32'h4000, "R3 w1c clears bit0 only");
    wr(2'd0, 32'h0);
    rd(2'd0, 32'h4000, "R3 writing zero changes nothing");

    // R4 event coincides with clear of same bit
    evt_i = 15'h0008;
    wr(2'd0, 32'h4008);
    evt_i = '0;
    rd(2'd0, 32'h0008, "R4 event beats same-cycle clear");

    wr(2'd0, 32'h7FFF);
    @(negedge clk);
    rd(2'd0, 32'h0, "R3 clear all");
    chk_irq(1'b0, "R5 irq drops when nothing pending");

    // R6 mask all then unmask one
    wr(2'd1, 32'hFFFF);
    rd(2'd1, 32'h7FFF, "R6 mask all reads 0x7FFF");
    pulse(15'h0200);
    @(negedge clk);
    chk_irq(1'b0, "R6 bus-off masked");
    wr(2'd1, 32'h7DFF);
    @(negedge clk);
    chk_irq(1'b1, "R5 bus-off unmasked raises irq");

    // R7 bus error capture
    berr_kind_i = 3'd4; berr_rx_i = 1'b1; berr_loc_i = 16'hBEEF;
    pulse(15'h0040);
    rd(2'd2, 32'h1200BEEF, "R7 crc error while receiving");
    // R9 hold with changed inputs
    berr_kind_i = 3'd1; berr_rx_i = 1'b0; berr_loc_i = 16'h1234;
    pulse(15'h0001);
    rd(2'd2, 32'h1200BEEF, "R9 errcode holds without event");
    berr_kind_i = 3'd2; berr_loc_i = 16'h0012;
    pulse(15'h0040);
    rd(2'd2, 32'h08000012, "R7 form error while transmitting");

    // R8 arbitration capture and R9 hold
    arb_code_i = 8'h2A;
    pulse(15'h0020);
    rd(2'd3, 32'h0000002A, "R8 arb code captured");
    arb_code_i = 8'h11;
    pulse(15'h0040);
    rd(2'd3, 32'h0000002A, "R9 arb holds without event");

    // R9 writes to read-only registers ignored
    wr(2'd2, 32'hFFFFFFFF);
    wr(2'd3, 32'hFFFFFFFF);
    rd(2'd2, 32'h08000012, "R9 errcode ignores write");
    rd(2'd3, 32'h0000002A, "R9 arb ignores write");

    // R10 status reflects accumulated events
    rd(2'd0, 32'h0261, "R10 status readback after activity");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule